// File: doc/BRIEF.md
# Operand-Adaptive 32x32 Unsigned Multiplier

This block multiplies two 32-bit unsigned operands into a 64-bit product using a single 16x16 multiplier shared across several clock cycles. In the general case the product is assembled from four 16x16 partial products. Each partial product is shifted by 0, 16 or 32 bits and added into a 64-bit accumulator.

Comparators examine both operands on the cycle a request is accepted. When the result needs less work, they pick a shorter route. A zero operand yields zero at once. An operand equal to one yields the other operand at once. When both operands fit in 16 bits, the single low-by-low partial product is enough. Every result comes with the number of cycles it took, so a caller can see which route was used.

Requests enter on a valid/ready pair. Back-pressure is simple: `in_ready` is high only while no computation is in flight, and a request is taken on any rising clock edge where `in_valid` and `in_ready` are both high. Results leave on a one-cycle `res_valid` strobe and cannot be stalled. `res_prod` and `res_cycles` keep their values until the next result, so a caller that misses the strobe can still read them.

Top module: `adaptive_mul32`

## Requirements
- R1: After reset, `in_ready` is 1, `res_valid` is 0, `res_prod` is 0 and `res_cycles` is 0.
- R2: A request is taken only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while a multi-cycle computation runs. Operands offered while `in_ready` is 0 are ignored: the next result is the product of the accepted pair.
- R3: If either operand is 0, `res_prod` is 0 and `res_cycles` is 1. `res_valid` rises right after the accepting edge, and `in_ready` stays 1.
- R4: If no operand is 0 and one operand equals 1, `res_prod` is the other operand, zero-extended to 64 bits. `res_cycles` is 1.
- R5: If no operand is 0 or 1 and both operands are below 2^16, the result arrives one edge after the accepting edge and `res_cycles` is 2.
- R6: In all other cases, the four partial products are computed on the four edges after the accepting edge and `res_cycles` is 5.
- R7: `res_valid` is high for exactly one cycle per accepted request. It is low while a computation runs. `res_prod` and `res_cycles` hold their values until the next result.
- R8: `res_prod` equals the exact 64-bit unsigned product of the accepted operands for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle; an offered pair is taken on the next edge |
| op_a | input | 32 | First unsigned operand |
| op_b | input | 32 | Second unsigned operand |
| res_valid | output | 1 | One-cycle strobe: a new result is present |
| res_prod | output | 64 | Unsigned product, held until the next result |
| res_cycles | output | 3 | Cycle count of the last result (1, 2 or 5) |

## Verification
Take edge k as the one that accepts a request. The result is due after edge k for the zero and one routes, after edge k+1 for the narrow route, and after edge k+4 for the wide route. `res_cycles` then reads 1, 2 or 5.

The bench drives and samples only on falling edges. It counts the falling edges from acceptance until `res_valid` is seen, and compares that count with both the expected latency and `res_cycles`. On the falling edge after that, it checks that the strobe has dropped and that the product is still held.

// File: rtl/amul_pkg.sv
package amul_pkg;
  typedef enum logic [1:0] {
    ROUTE_ZERO   = 2'd0,
    ROUTE_UNIT   = 2'd1,
    ROUTE_NARROW = 2'd2,
    ROUTE_WIDE   = 2'd3
  } route_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/amul_classify.sv
module amul_classify
  import amul_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] a,
  input  logic [2*HALF_W-1:0] b,
  output route_e              route,
  output logic [2*HALF_W-1:0] bypass_val
);
  localparam int W = 2 * HALF_W;

  logic a_zero, b_zero, a_unit, b_unit, a_narrow, b_narrow;

  always_comb begin
    a_zero   = (a == '0);
    b_zero   = (b == '0);
    a_unit   = (a == W'(1));
    b_unit   = (b == W'(1));
    a_narrow = (a[W-1:HALF_W] == '0);
    b_narrow = (b[W-1:HALF_W] == '0);
  end

  always_comb begin
    bypass_val = '0;
    if (a_zero || b_zero) begin
      route = ROUTE_ZERO;
    end else if (a_unit) begin
      route      = ROUTE_UNIT;
      bypass_val = b;
    end else if (b_unit) begin
      route      = ROUTE_UNIT;
      bypass_val = a;
    end else if (a_narrow && b_narrow) begin
      route = ROUTE_NARROW;
    end else begin
      route = ROUTE_WIDE;
    end
  end
endmodule

// File: rtl/amul_pp_unit.sv
module amul_pp_unit #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] a,
  input  logic [2*HALF_W-1:0] b,
  input  logic [1:0]          step,
  output logic [4*HALF_W-1:0] pp_shifted
);
  localparam int W      = 2 * HALF_W;
  localparam int PROD_W = 2 * W;

  logic [HALF_W-1:0] a_half, b_half;
  logic [W-1:0]      pp;
  logic [1:0]        weight;

  // step[1] selects the half of a, step[0] the half of b
  always_comb begin
    a_half = step[1] ? a[W-1:HALF_W] : a[HALF_W-1:0];
    b_half = step[0] ? b[W-1:HALF_W] : b[HALF_W-1:0];
    pp     = W'(a_half) * W'(b_half);
    weight = 2'(step[1]) + 2'(step[0]);
  end

  always_comb begin
    case (weight)
      2'd0:    pp_shifted = PROD_W'(pp);
      2'd1:    pp_shifted = PROD_W'(pp) << HALF_W;
      default: pp_shifted = PROD_W'(pp) << W;
    endcase
  end
endmodule

// File: rtl/amul_ctrl.sv
module amul_ctrl
  import amul_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*HALF_W-1:0] op_a,
  input  logic [2*HALF_W-1:0] op_b,
  input  route_e              route,
  input  logic [2*HALF_W-1:0] bypass_val,
  input  logic [4*HALF_W-1:0] pp_shifted,
  output logic [2*HALF_W-1:0] a_q,
  output logic [2*HALF_W-1:0] b_q,
  output logic [1:0]          step_q,
  output logic                idle,
  output logic                res_valid,
  output logic [4*HALF_W-1:0] res_prod,
  output logic [CNT_W-1:0]    res_cycles
);
  localparam int W      = 2 * HALF_W;
  localparam int PROD_W = 2 * W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  ctrl_state_e       state_q;
  logic [1:0]        last_q;
  logic [PROD_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PROD_W-1:0] sum;
  logic              accept;

  assign idle   = (state_q == ST_IDLE);
  assign accept = in_valid && idle;
  assign sum    = acc_q + pp_shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      a_q        <= '0;
      b_q        <= '0;
      step_q     <= '0;
      last_q     <= '0;
      acc_q      <= '0;
      cnt_q      <= '0;
      res_valid  <= 1'b0;
      res_prod   <= '0;
      res_cycles <= '0;
    end else begin
      res_valid <= 1'b0;
      if (accept) begin
        cnt_q <= CNT_ONE;
        if (route == ROUTE_ZERO || route == ROUTE_UNIT) begin
          res_prod   <= PROD_W'(bypass_val);
          res_cycles <= CNT_ONE;
          res_valid  <= 1'b1;
        end else begin
          a_q     <= op_a;
          b_q     <= op_b;
          step_q  <= 2'd0;
          last_q  <= (route == ROUTE_NARROW) ? 2'd0 : 2'd3;
          acc_q   <= '0;
          state_q <= ST_RUN;
        end
      end else if (state_q == ST_RUN) begin
        cnt_q  <= cnt_q + CNT_ONE;
        step_q <= step_q + 2'd1;
        if (step_q == last_q) begin
          res_prod   <= sum;
          res_cycles <= cnt_q + CNT_ONE;
          res_valid  <= 1'b1;
          state_q    <= ST_IDLE;
        end else begin
          acc_q <= sum;
        end
      end
    end
  end

  // R2: captured operands stay put while a computation runs
  a_r2_ops_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> ($stable(a_q) && $stable(b_q)));

  // R3: zero route answers on the accepting edge with zero
  a_r3_zero_route: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route == ROUTE_ZERO) |=> (res_valid && res_prod == '0 && res_cycles == CNT_ONE));

  // R4: unit route answers on the accepting edge
  a_r4_unit_route: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route == ROUTE_UNIT) |=> (res_valid && res_cycles == CNT_ONE && idle));

  // R5: narrow route answers one edge later
  a_r5_narrow_route: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route == ROUTE_NARROW) |-> ##2 (res_valid && res_cycles == CNT_W'(2)));

  // R6: wide route answers four edges later
  a_r6_wide_route: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route == ROUTE_WIDE) |-> ##5 (res_valid && res_cycles == CNT_W'(5)));

  // R7: no result strobe while a computation is in flight
  a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> !res_valid);
endmodule

// File: rtl/adaptive_mul32.sv
module adaptive_mul32
  import amul_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2*HALF_W-1:0] op_a,
  input  logic [2*HALF_W-1:0] op_b,
  output logic                res_valid,
  output logic [4*HALF_W-1:0] res_prod,
  output logic [CNT_W-1:0]    res_cycles
);
  localparam int W      = 2 * HALF_W;
  localparam int PROD_W = 2 * W;

  route_e            route;
  logic [W-1:0]      bypass_val;
  logic [W-1:0]      a_q, b_q;
  logic [1:0]        step_q;
  logic [PROD_W-1:0] pp_shifted;
  logic              idle;

  amul_classify #(.HALF_W(HALF_W)) i_classify (
    .a          (op_a),
    .b          (op_b),
    .route      (route),
    .bypass_val (bypass_val)
  );

  amul_pp_unit #(.HALF_W(HALF_W)) i_pp (
    .a          (a_q),
    .b          (b_q),
    .step       (step_q),
    .pp_shifted (pp_shifted)
  );

  amul_ctrl #(.HALF_W(HALF_W), .CNT_W(CNT_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .route      (route),
    .bypass_val (bypass_val),
    .pp_shifted (pp_shifted),
    .a_q        (a_q),
    .b_q        (b_q),
    .step_q     (step_q),
    .idle       (idle),
    .res_valid  (res_valid),
    .res_prod   (res_prod),
    .res_cycles (res_cycles)
  );

  assign in_ready = idle;

  // R1: a fresh block is ready and silent
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !res_valid));

  // R2: acceptance without ready never produces an extra result in the next cycle
  a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !$past(in_ready)) |-> !res_valid);
endmodule

// File: tb/test_adaptive_mul32.sv
module test_adaptive_mul32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        res_valid;
  logic [63:0] res_prod;
  logic [2:0]  res_cycles;

  int checks = 0;
  int errors = 0;
  bit done_all = 1'b0;

  always #5 clk = ~clk;

  adaptive_mul32 i_adaptive_mul32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid),
    .res_prod(res_prod), .res_cycles(res_cycles)
  );

  function automatic int exp_cycles(input logic [31:0] a, input logic [31:0] b);
    if (a == 0 || b == 0) return 1;
    if (a == 1 || b == 1) return 1;
    if (a < 32'h10000 && b < 32'h10000) return 2;
    return 5;
  endfunction

  function automatic string route_req(input logic [31:0] a, input logic [31:0] b);
    if (a == 0 || b == 0) return "R3";
    if (a == 1 || b == 1) return "R4";
    if (a < 32'h10000 && b < 32'h10000) return "R5";
    return "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit noise);
    logic [63:0] exp_p;
    int exp_c;
    int n;
    string rq;
    exp_p = {32'b0, a} * {32'b0, b};
    exp_c = exp_cycles(a, b);
    rq    = route_req(a, b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    chk(in_ready == (exp_c == 1), "R2", "ready during computation",
        64'(in_ready), 64'(exp_c == 1));
    while (!res_valid && n < 30) begin
      if (noise && !in_ready) begin
        in_valid = 1'b1; op_a = $urandom; op_b = $urandom;
      end
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    chk(n < 30, "R7", "result strobe timeout", 64'(n), 64'(exp_c));
    chk(n == exp_c, rq, "latency", 64'(n), 64'(exp_c));
    chk(res_cycles == 3'(exp_c), rq, "reported cycles", 64'(res_cycles), 64'(exp_c));
    chk(res_prod == exp_p, noise ? "R2" : "R8", "product", res_prod, exp_p);
    @(negedge clk);
    chk(!res_valid, "R7", "strobe one cycle", 64'(res_valid), 64'd0);
    chk(res_prod == exp_p, "R7", "product held", res_prod, exp_p);
  endtask

  function automatic logic [31:0] pick(input int kind);
    case (kind)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'($urandom_range(2, 65535));
      3: return 32'hFFFF;
      4: return 32'h10000;
      5: return 32'hFFFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    int seed_use;
    seed_use = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "reset ready", 64'(in_ready), 64'd1);
    chk(res_valid == 1'b0, "R1", "reset valid", 64'(res_valid), 64'd0);
    chk(res_prod == 64'd0, "R1", "reset product", res_prod, 64'd0);
    chk(res_cycles == 3'd0, "R1", "reset cycles", 64'(res_cycles), 64'd0);
    rst_n = 1'b1;

    // directed corners
    run_op(32'd0, 32'hFFFFFFFF, 1'b0);        // R3
    run_op(32'h12345678, 32'd0, 1'b0);        // R3
    run_op(32'd0, 32'd1, 1'b0);               // R3 zero wins over one
    run_op(32'd1, 32'hDEADBEEF, 1'b0);        // R4
    run_op(32'hCAFEF00D, 32'd1, 1'b0);        // R4
    run_op(32'd1, 32'd1, 1'b0);               // R4
    run_op(32'hFFFF, 32'hFFFF, 1'b0);         // R5
    run_op(32'd2, 32'd3, 1'b0);               // R5
    run_op(32'h10000, 32'h10000, 1'b0);       // R6
    run_op(32'hFFFF, 32'h10000, 1'b0);        // R6
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0); // R6 and R8
    run_op(32'h80000000, 32'd2, 1'b0);        // R6
    run_op(32'hFFFFFFFF, 32'hFFFF, 1'b1);     // R2 noise ignored
    run_op(32'h1234, 32'h5678, 1'b1);         // R2 noise ignored

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = pick($urandom_range(0, 8));
      b = pick($urandom_range(0, 8));
      run_op(a, b, 1'($urandom_range(0, 1)));
    end

    done_all = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done_all) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule